// File: doc/BRIEF.md
# Asynchronous Serial Port with Error Flags

This block is a full-duplex asynchronous serial transmitter and receiver, driven from a small register bus. A character on the line is a low start bit, eight data bits sent least significant first, an optional parity bit (even or odd), and one or two high stop bits. Each bit lasts sixteen ticks of an oversampling clock. That clock is taken either from one of seven fixed divisions of the system clock or from an external timer tick.

Software writes the control word and then writes bytes into a one-deep holding register. The transmitter moves each byte into its shift register as soon as the shift register is free. Received bytes land in a one-deep receive buffer. A status word carries six flags. A one-cycle interrupt pulse marks each received byte, and another marks each time the transmit holding register becomes free.

Register map (reg_addr): 0 = control (read/write), 1 = status (read; a write of 1 to bit 3 clears the overrun flag), 2 = data (a write loads the transmit holding register, a read returns the receive buffer). Control bits: bit 0 enables parity, bit 1 selects odd parity, bit 2 selects two stop bits, bits 5:3 select the rate. Status bits: 0 transmit holding empty, 1 transmitter finished, 2 receive buffer full, 3 overrun, 4 framing error, 5 parity error. Read data appears on reg_rdata in the cycle after reg_rd is sampled high.

Top module: `serlink_uart`

## Requirements
- R1: After reset the status reads 8'h03 (holding empty and transmitter finished, all other flags 0), the control word reads 0, txd is high and both interrupt outputs are low.
- R2: The transmitter sends a low start bit, the 8 data bits least significant first, the parity bit when enabled, and then one stop bit (control bit 2 = 0) or two stop bits (control bit 2 = 1), each high. txd stays high while the transmitter is finished.
- R3: Parity is enabled by control bit 0. Control bit 1 = 0 gives even parity, so the data bits and the parity bit together hold an even number of ones. Control bit 1 = 1 gives odd parity.
- R4: Every bit lasts 16 oversampling ticks. Rate select values 0 to 5 give a tick every 13, 26, 52, 104, 208 or 416 system clocks, value 6 gives one tick per ext_tick pulse, and value 7 gives a tick every 96 clocks.
- R5: Writing the data register clears status bits 0 and 1. When the held byte moves into the shift register, status bit 0 is set and irq_tx pulses high for one cycle.
- R6: Status bit 1 is set only once the last stop bit has been shifted out and the holding register is empty. It stays 0 while a frame is being sent.
- R7: A received byte is loaded into the receive buffer. This sets status bit 2 and pulses irq_rx for one cycle. Reading the data register clears status bits 2, 4 and 5.
- R8: Status bit 5 is set when parity is enabled and the received parity bit disagrees with the parity computed from the received data. The byte is still loaded.
- R9: Status bit 4 is set when the first stop bit is sampled low. The receiver does not start a new frame until the line has been seen high again.
- R10: If a frame completes while status bit 2 is set, status bit 3 is set and the buffer keeps its old byte. While status bit 3 is set no new frame is started. Writing 8'h08 to the status address clears it.
- R11: A low pulse on rxd that has ended before the middle of the start bit (8 ticks) starts no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data |
| ext_tick | input | 1 | External timer tick used when rate select is 6 |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| irq_rx | output | 1 | One-cycle pulse on each byte loaded into the receive buffer |
| irq_tx | output | 1 | One-cycle pulse when the holding register is moved to the shifter |

## Verification
The hardest state to reach is the receive lock. Getting there needs a second complete frame to arrive while the first byte is still unread. The bench must then show that a third frame leaves the buffer flag clear, that clearing the overrun flag re-arms reception, and that a fourth byte then arrives intact. The stimulus builds this by sending frames bit by bit on rxd without reading in between. It then drives a frame with a bad stop bit followed by a clean frame, to show that the receiver recovers after a break-like low. Finally it drives a short low glitch, to show that a false start bit is rejected.

// File: rtl/serlink_pkg.sv
package serlink_pkg;
  localparam int DATA_W  = 8;
  localparam int OVS_W   = 4;
  localparam int FRAME_W = DATA_W + 4;
  localparam int ADDR_W  = 2;

  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_STAT = 2'd1;
  localparam logic [ADDR_W-1:0] A_DATA = 2'd2;

  localparam int S_TXE   = 0;
  localparam int S_TXEND = 1;
  localparam int S_RXF   = 2;
  localparam int S_OVR   = 3;
  localparam int S_FE    = 4;
  localparam int S_PE    = 5;
  localparam int ST_W    = 6;

  localparam logic [2:0] SEL_EXT = 3'd6;
  localparam logic [2:0] SEL_ALT = 3'd7;
endpackage

// File: rtl/serlink_baud.sv
module serlink_baud
  import serlink_pkg::*;
#(
  parameter int BASE_DIV = 13,
  parameter int ALT_DIV  = 96
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] sel,
  input  logic       ext_tick,
  output logic       tick
);
  localparam int TOP_DIV = BASE_DIV << 5;
  localparam int MAXDIV  = (TOP_DIV > ALT_DIV) ? TOP_DIV : ALT_DIV;
  localparam int CW      = $clog2(MAXDIV);

  logic [CW-1:0] cnt, lim;

  always_comb begin
    if (sel == SEL_ALT) lim = CW'(ALT_DIV - 1);
    else                lim = CW'((BASE_DIV << sel) - 1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (sel == SEL_EXT) begin
      cnt  <= '0;
      tick <= ext_tick;
    end else if (cnt >= lim) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/serlink_tx.sv
module serlink_tx
  import serlink_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              load,
  input  logic [DATA_W-1:0] wdata,
  input  logic              par_en,
  input  logic              odd,
  input  logic              two_stop,
  output logic              txd,
  output logic              empty,
  output logic              fin,
  output logic              irq
);
  localparam int BL_W = $clog2(FRAME_W + 1);

  logic [DATA_W-1:0]  hold;
  logic               hold_full, busy;
  logic [FRAME_W-1:0] shreg, frame;
  logic [BL_W-1:0]    bits_left, nbits;
  logic [OVS_W-1:0]   tcnt;
  logic               par;

  assign par   = ^hold ^ odd;
  assign nbits = BL_W'(DATA_W + 2) + BL_W'(par_en) + BL_W'(two_stop);

  always_comb begin
    if (par_en) frame = {2'b11, par, hold, 1'b0};
    else        frame = {3'b111, hold, 1'b0};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold      <= '0;
      hold_full <= 1'b0;
      busy      <= 1'b0;
      shreg     <= '1;
      bits_left <= '0;
      tcnt      <= '0;
      fin       <= 1'b1;
      irq       <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (!busy && hold_full) begin
        shreg     <= frame;
        bits_left <= nbits;
        busy      <= 1'b1;
        tcnt      <= '0;
        hold_full <= 1'b0;
        irq       <= 1'b1;
      end else if (busy && tick) begin
        tcnt <= tcnt + 1'b1;
        if (tcnt == '1) begin
          shreg     <= {1'b1, shreg[FRAME_W-1:1]};
          bits_left <= bits_left - 1'b1;
          if (bits_left == BL_W'(1)) begin
            busy <= 1'b0;
            if (!hold_full && !load) fin <= 1'b1;
          end
        end
      end
      if (load) begin
        hold      <= wdata;
        hold_full <= 1'b1;
        fin       <= 1'b0;
      end
    end
  end

  assign txd   = shreg[0];
  assign empty = ~hold_full;
endmodule

// File: rtl/serlink_rx.sv
module serlink_rx
  import serlink_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              rxd,
  input  logic              lock,
  input  logic              par_en,
  output logic              busy,
  output logic              done,
  output logic              stop_ok,
  output logic              par_bit,
  output logic [DATA_W-1:0] data
);
  localparam int BI_W = $clog2(DATA_W + 3);
  localparam logic [OVS_W-1:0] MID = OVS_W'((1 << OVS_W) / 2 - 1);

  logic [1:0]       sync;
  logic             line, armed, hunting;
  logic [OVS_W-1:0] tcnt;
  logic [BI_W-1:0]  bidx;

  assign line = sync[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sync    <= 2'b11;
      armed   <= 1'b0;
      busy    <= 1'b0;
      hunting <= 1'b0;
      tcnt    <= '0;
      bidx    <= '0;
      done    <= 1'b0;
      stop_ok <= 1'b1;
      par_bit <= 1'b0;
      data    <= '0;
    end else begin
      sync <= {sync[0], rxd};
      done <= 1'b0;
      if (line) armed <= 1'b1;
      if (tick) begin
        if (!busy) begin
          if (!line && armed && !lock) begin
            busy    <= 1'b1;
            hunting <= 1'b1;
            armed   <= 1'b0;
            tcnt    <= '0;
          end
        end else begin
          tcnt <= tcnt + 1'b1;
          if (hunting) begin
            if (tcnt == MID) begin
              if (line) busy <= 1'b0;
              else begin
                hunting <= 1'b0;
                tcnt    <= '0;
                bidx    <= '0;
              end
            end
          end else if (tcnt == '1) begin
            bidx <= bidx + 1'b1;
            if (bidx < BI_W'(DATA_W)) data <= {line, data[DATA_W-1:1]};
            else if (bidx == BI_W'(DATA_W) && par_en) par_bit <= line;
            else begin
              stop_ok <= line;
              done    <= 1'b1;
              busy    <= 1'b0;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/serlink_uart.sv
module serlink_uart
  import serlink_pkg::*;
#(
  parameter int BASE_DIV = 13,
  parameter int ALT_DIV  = 96
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              ext_tick,
  input  logic              rxd,
  output logic              txd,
  output logic              irq_rx,
  output logic              irq_tx
);
  logic [5:0]        ctrl;
  logic              par_en, odd, two_stop;
  logic [2:0]        sel;
  logic              tick;
  logic              tx_empty, tx_fin;
  logic              rx_busy, rx_done, rx_stop_ok, rx_par;
  logic [DATA_W-1:0] rx_data, rx_buf;
  logic              rx_full, ovr_f, fe_f, pe_f, pe_calc;
  logic [ST_W-1:0]   status;

  assign par_en   = ctrl[0];
  assign odd      = ctrl[1];
  assign two_stop = ctrl[2];
  assign sel      = ctrl[5:3];

  serlink_baud #(.BASE_DIV(BASE_DIV), .ALT_DIV(ALT_DIV)) u_baud (
    .clk(clk), .rst(rst), .sel(sel), .ext_tick(ext_tick), .tick(tick)
  );

  serlink_tx u_tx (
    .clk(clk), .rst(rst), .tick(tick),
    .load(reg_wr && reg_addr == A_DATA), .wdata(reg_wdata),
    .par_en(par_en), .odd(odd), .two_stop(two_stop),
    .txd(txd), .empty(tx_empty), .fin(tx_fin), .irq(irq_tx)
  );

  serlink_rx u_rx (
    .clk(clk), .rst(rst), .tick(tick), .rxd(rxd), .lock(ovr_f),
    .par_en(par_en), .busy(rx_busy), .done(rx_done),
    .stop_ok(rx_stop_ok), .par_bit(rx_par), .data(rx_data)
  );

  assign pe_calc = par_en && (rx_par != (^rx_data ^ odd));

  always_comb begin
    status          = '0;
    status[S_TXE]   = tx_empty;
    status[S_TXEND] = tx_fin;
    status[S_RXF]   = rx_full;
    status[S_OVR]   = ovr_f;
    status[S_FE]    = fe_f;
    status[S_PE]    = pe_f;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl      <= '0;
      rx_buf    <= '0;
      rx_full   <= 1'b0;
      ovr_f     <= 1'b0;
      fe_f      <= 1'b0;
      pe_f      <= 1'b0;
      irq_rx    <= 1'b0;
      reg_rdata <= '0;
    end else begin
      irq_rx <= 1'b0;
      if (reg_wr && reg_addr == A_CTRL) ctrl <= reg_wdata[5:0];
      if (reg_wr && reg_addr == A_STAT && reg_wdata[S_OVR]) ovr_f <= 1'b0;
      if (reg_rd && reg_addr == A_DATA) begin
        rx_full <= 1'b0;
        fe_f    <= 1'b0;
        pe_f    <= 1'b0;
      end
      if (rx_done) begin
        if (rx_full) ovr_f <= 1'b1;
        else begin
          rx_buf  <= rx_data;
          rx_full <= 1'b1;
          fe_f    <= ~rx_stop_ok;
          pe_f    <= pe_calc;
          irq_rx  <= 1'b1;
        end
      end
      if (reg_rd) begin
        case (reg_addr)
          A_CTRL:  reg_rdata <= {2'b00, ctrl};
          A_STAT:  reg_rdata <= DATA_W'(status);
          A_DATA:  reg_rdata <= rx_buf;
          default: reg_rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/serlink_uart_chk.sv
module serlink_uart_chk
  import serlink_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input logic            txd,
  input logic            irq_rx,
  input logic            irq_tx,
  input logic [ST_W-1:0] st,
  input logic            rx_busy
);
  AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (rst) st[S_TXEND] |-> txd); // R2
  AST_TXE_WITH_IRQ: assert property (@(posedge clk) disable iff (rst) irq_tx |-> st[S_TXE]); // R5
  AST_IRQ_TX_PULSE: assert property (@(posedge clk) disable iff (rst) irq_tx |=> !irq_tx); // R5
  AST_FIN_NEEDS_EMPTY: assert property (@(posedge clk) disable iff (rst) st[S_TXEND] |-> st[S_TXE]); // R6
  AST_RX_IRQ_FULL: assert property (@(posedge clk) disable iff (rst) irq_rx |-> st[S_RXF]); // R7
  AST_RX_IRQ_PULSE: assert property (@(posedge clk) disable iff (rst) irq_rx |=> !irq_rx); // R7
  AST_OVR_LOCK: assert property (@(posedge clk) disable iff (rst) $rose(rx_busy) |-> !$past(st[S_OVR])); // R10
endmodule

bind serlink_uart serlink_uart_chk u_chk (
  .clk(clk), .rst(rst), .txd(txd), .irq_rx(irq_rx), .irq_tx(irq_tx),
  .st(status), .rx_busy(rx_busy)
);

// File: tb/serlink_uart_bench.sv
module serlink_uart_bench;
  localparam int BIT = 16 * 13;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       ext_tick = 1'b0;
  logic       rxd = 1'b1;
  logic       txd, irq_rx, irq_tx;

  int n_chk = 0, n_fail = 0, n_irq_tx = 0, n_irq_rx = 0;
  bit finished = 1'b0, mon_on = 1'b0;
  bit cfg_pe = 1'b0, cfg_odd = 1'b0, cfg_two = 1'b0;
  logic [7:0] txq[$];

  serlink_uart u_serlink_uart (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_tick(ext_tick),
    .rxd(rxd), .txd(txd), .irq_rx(irq_rx), .irq_tx(irq_tx)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (irq_tx) n_irq_tx++;
    if (irq_rx) n_irq_rx++;
  end

  initial begin
    forever begin
      repeat (19) @(negedge clk);
      ext_tick = 1'b1;
      @(negedge clk);
      ext_tick = 1'b0;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic config_line(input bit pe, input bit od, input bit two);
    cfg_pe = pe; cfg_odd = od; cfg_two = two;
    wr(2'd0, {5'b0, two, od, pe});
  endtask

  // driver: push expected byte into the scoreboard, then load it
  task automatic send_tx(input logic [7:0] d);
    txq.push_back(d);
    wr(2'd2, d);
  endtask

  task automatic send_rx(input logic [7:0] d, input bit bad_par, input bit bad_stop);
    rxd = 1'b0;
    repeat (BIT) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = d[i];
      repeat (BIT) @(negedge clk);
    end
    if (cfg_pe) begin
      rxd = ^d ^ cfg_odd ^ bad_par;
      repeat (BIT) @(negedge clk);
    end
    rxd = ~bad_stop;
    repeat (BIT) @(negedge clk);
    rxd = 1'b1;
    repeat (BIT) @(negedge clk);
  endtask

  task automatic measure(input logic [7:0] ctl, input int exp_len, input int tol, input string tag);
    int len;
    wr(2'd0, ctl);
    wr(2'd2, 8'h00);
    while (txd !== 1'b0) @(negedge clk);
    len = 0;
    while (txd === 1'b0) begin
      len++;
      @(negedge clk);
    end
    chk(tag, (len >= exp_len - tol && len <= exp_len + tol) ? exp_len : len, exp_len);
    repeat (exp_len / 4) @(negedge clk);
  endtask

  // monitor: decode txd and compare against the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (mon_on && txd === 1'b0) begin
        logic [7:0] got;
        logic [7:0] exp;
        logic pbit, s1, s2, st0;
        repeat (BIT / 2) @(negedge clk);
        st0 = txd;
        for (int i = 0; i < 8; i++) begin
          repeat (BIT) @(negedge clk);
          got[i] = txd;
        end
        pbit = 1'b0;
        if (cfg_pe) begin
          repeat (BIT) @(negedge clk);
          pbit = txd;
        end
        repeat (BIT) @(negedge clk);
        s1 = txd;
        s2 = 1'b1;
        if (cfg_two) begin
          repeat (BIT) @(negedge clk);
          s2 = txd;
        end
        if (txq.size() == 0) begin
          chk("R2 unexpected tx frame", 1, 0);
        end else begin
          exp = txq.pop_front();
          chk("R2 tx start bit", int'(st0), 0);
          chk("R2 tx data", int'(got), int'(exp));
          chk("R2 tx stop bits", int'({s1, s2}), 3);
          if (cfg_pe) chk("R3 tx parity bit", int'(pbit), int'(^exp ^ cfg_odd));
        end
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 txd idle", int'(txd), 1);
    chk("R1 irqs low", int'({irq_rx, irq_tx}), 0);
    rd(2'd1, v); chk("R1 status", v, 8'h03);
    rd(2'd0, v); chk("R1 control", v, 8'h00);

    // R5 R6 transmit path, even parity one stop
    config_line(1'b1, 1'b0, 1'b0);
    mon_on = 1'b1;
    send_tx(8'hA5);
    send_tx(8'h3C);
    rd(2'd1, v); chk("R5 held byte clears empty and end", v & 8'h03, 8'h00);
    repeat (11 * BIT + 400) @(negedge clk);
    rd(2'd1, v); chk("R6 end stays low mid-frame", v & 8'h03, 8'h01);
    while (txq.size() != 0) @(negedge clk);
    repeat (2 * BIT) @(negedge clk);
    rd(2'd1, v); chk("R6 end after last stop", v & 8'h03, 8'h03);
    chk("R5 irq_tx pulses", n_irq_tx, 2);

    // R2 R3 odd parity two stops, then no parity
    config_line(1'b1, 1'b1, 1'b1);
    send_tx(8'h81);
    while (txq.size() != 0) @(negedge clk);
    repeat (2 * BIT) @(negedge clk);
    config_line(1'b0, 1'b0, 1'b0);
    send_tx(8'h5A);
    while (txq.size() != 0) @(negedge clk);
    repeat (2 * BIT) @(negedge clk);
    mon_on = 1'b0;

    // R7 clean receive, even parity
    config_line(1'b1, 1'b0, 1'b0);
    send_rx(8'hC3, 1'b0, 1'b0);
    chk("R7 irq_rx pulse", n_irq_rx, 1);
    rd(2'd1, v); chk("R7 buffer full", v, 8'h07);
    rd(2'd2, v); chk("R7 data", v, 8'hC3);
    rd(2'd1, v); chk("R7 read clears full", v, 8'h03);

    // R8 parity error
    send_rx(8'h96, 1'b1, 1'b0);
    rd(2'd1, v); chk("R8 parity flag", v, 8'h27);
    rd(2'd2, v); chk("R8 data kept", v, 8'h96);
    rd(2'd1, v); chk("R8 cleared by read", v, 8'h03);

    // R9 framing error, then recovery
    send_rx(8'h11, 1'b0, 1'b1);
    rd(2'd1, v); chk("R9 framing flag", v, 8'h17);
    rd(2'd2, v); chk("R9 data", v, 8'h11);
    send_rx(8'h22, 1'b0, 1'b0);
    rd(2'd1, v); chk("R9 recovery status", v, 8'h07);
    rd(2'd2, v); chk("R9 recovery data", v, 8'h22);

    // R3 odd parity receive
    config_line(1'b1, 1'b1, 1'b0);
    send_rx(8'h96, 1'b0, 1'b0);
    rd(2'd1, v); chk("R3 odd parity accepted", v, 8'h07);
    rd(2'd2, v); chk("R3 odd data", v, 8'h96);

    // R10 overrun and lock
    config_line(1'b1, 1'b0, 1'b0);
    send_rx(8'h01, 1'b0, 1'b0);
    send_rx(8'h02, 1'b0, 1'b0);
    rd(2'd1, v); chk("R10 overrun flag", v, 8'h0F);
    rd(2'd2, v); chk("R10 old byte kept", v, 8'h01);
    send_rx(8'h03, 1'b0, 1'b0);
    rd(2'd1, v); chk("R10 locked receiver", v, 8'h0B);
    wr(2'd1, 8'h08);
    rd(2'd1, v); chk("R10 overrun cleared", v, 8'h03);
    send_rx(8'h04, 1'b0, 1'b0);
    rd(2'd2, v); chk("R10 reception resumes", v, 8'h04);

    // R11 short low glitch
    rxd = 1'b0;
    repeat (40) @(negedge clk);
    rxd = 1'b1;
    repeat (14 * BIT) @(negedge clk);
    rd(2'd1, v); chk("R11 glitch ignored", v, 8'h03);
    send_rx(8'h7E, 1'b0, 1'b0);
    rd(2'd2, v); chk("R11 later frame", v, 8'h7E);

    // R4 rate selection: start plus eight zero bits low
    measure(8'h08, 9 * 16 * 26, 26, "R4 rate select 1");
    measure(8'h38, 9 * 16 * 96, 96, "R4 rate select 7");
    measure(8'h30, 9 * 16 * 20, 20, "R4 external tick");

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule